// File: doc/BRIEF.md
# Half-Bridge Duty-Cycle Regulator

This block produces the high-side and low-side gate enables that drive a resonant antenna tank through a half-bridge. It runs on a slot clock. One carrier period is `2 * 2**DUTY_W` slots. The first half of each period is the window in which the high-side device may conduct. The high-side on-time is set by a duty code that counts in units of `1/2**DUTY_W` of that half period. A duty of `2**DUTY_W` therefore means the high side conducts for the whole half period.

Each burst begins at half duty. On every period boundary the block samples two comparator flags:

- `pk_over`: the sensed peak is above target.
- `pk_gross`: the sensed peak is above target plus a large margin.

With neither flag set, the duty climbs in large steps toward its ceiling. With either flag set, it falls in small steps toward a floor. A gross overshoot also removes the entire high-side pulse of the following period. Because of this loop, a higher supply settles at a lower duty for the same antenna current.

One all-off slot separates every switch between the two devices. A protection input puts both devices in the off (tri-state) state at once, ahead of all other logic. While drive is not requested, the low-side device holds the antenna node at ground.

The sequencer has four states, and `GS_IDLE` is the reset state:

- `GS_IDLE`: low side on.
- `GS_LEAD`: one all-off slot before a burst.
- `GS_RUN`: periods are generated.
- `GS_TAIL`: one all-off slot after a burst.

Its transitions are:

- IDLE→LEAD when `drv_en` rises.
- LEAD→RUN when `drv_en` is still high.
- LEAD→IDLE when `drv_en` dropped.
- RUN→TAIL when `drv_en` falls.
- TAIL→IDLE always.

Top module: `hb_duty_regulator`

## Requirements
- R1: Entering GS_LEAD loads the duty code with START_DUTY (default 32 of 64), so the first period of every burst has exactly 32 high-side slots.
- R2: A period boundary at which both pk_over and pk_gross are 0 raises the duty by UP_STEP (default 11), so from 32 the ceiling is reached after three boundaries.
- R3: The duty never exceeds MAX_DUTY (default 64); at 64 the high side is on for the whole first half (slots 0..63).
- R4: A period boundary at which pk_over or pk_gross is 1 lowers the duty by DN_STEP (default 4), but never below MIN_DUTY (default 9).
- R5: pk_gross = 1 at a period boundary suppresses the whole high-side pulse of the next period; that period has the low side on for slots 0..126.
- R6: In GS_RUN, a period with duty d (slots 0..127) has the high side on for slots 0..d-1, both off at slot d and slot 127, and the low side on for slots d+1..126.
- R7: Out of reset and in GS_IDLE the low side is on and the high side off; the slot in GS_LEAD and the slot in GS_TAIL have both off.
- R8: hs_on and ls_on are never 1 together, and neither turns on in the slot right after the other was on.
- R9: prot_off = 1 forces hs_on and ls_on to 0 in the same cycle, whatever the state.
- R10: The flags are sampled only in slot 127; values present earlier in the period and gone by slot 127 do not change the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, 2*2**DUTY_W slots per carrier period |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_en | input | 1 | Drive burst request |
| pk_over | input | 1 | Peak current above target |
| pk_gross | input | 1 | Peak current above target plus margin |
| prot_off | input | 1 | Protection: force both devices off |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with its default parameters: DUTY_W = 6 (128-slot periods), START_DUTY = 32, UP_STEP = 11, DN_STEP = 4, MIN_DUTY = 9 and MAX_DUTY = 64. With these values a burst reaches full duty in three periods and, under a steady over-limit flag, falls from 32 to the floor in six. Clamping at both ends, a skipped period and a burst restart therefore all fit in about twenty periods, and every slot of each of those periods is compared against the expected pattern.

// File: rtl/hbr_pkg.sv
`timescale 1ns/1ps
package hbr_pkg;
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_LEAD = 2'd1,
        GS_RUN  = 2'd2,
        GS_TAIL = 2'd3
    } gate_state_t;
endpackage

// File: rtl/hbr_phase_ctr.sv
`timescale 1ns/1ps
module hbr_phase_ctr #(
    parameter int DUTY_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [DUTY_W:0] phase,
    output logic            period_end
);
    localparam int PW = DUTY_W + 1;
    localparam logic [PW-1:0] LAST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign period_end = run && (phase == LAST);
endmodule

// File: rtl/hbr_duty_servo.sv
`timescale 1ns/1ps
module hbr_duty_servo #(
    parameter int DUTY_W     = 6,
    parameter int START_DUTY = 32,
    parameter int UP_STEP    = 11,
    parameter int DN_STEP    = 4,
    parameter int MIN_DUTY   = 9,
    parameter int MAX_DUTY   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            period_end,
    input  logic            pk_over,
    input  logic            pk_gross,
    output logic [DUTY_W:0] duty,
    output logic            skip
);
    localparam int CW = DUTY_W + 1;
    localparam int SW = DUTY_W + 2;
    localparam logic [SW-1:0] UPV    = SW'(UP_STEP);
    localparam logic [SW-1:0] MAXW   = SW'(MAX_DUTY);
    localparam logic [CW-1:0] MAXC   = CW'(MAX_DUTY);
    localparam logic [CW-1:0] DNV    = CW'(DN_STEP);
    localparam logic [CW-1:0] MINV   = CW'(MIN_DUTY);
    localparam logic [CW-1:0] FLOORV = CW'(MIN_DUTY + DN_STEP);
    localparam logic [CW-1:0] STARTV = CW'(START_DUTY);

    logic [SW-1:0] raised;
    logic [CW-1:0] up_val;
    logic [CW-1:0] dn_val;
    logic [CW-1:0] duty_nxt;

    always_comb begin
        raised   = {1'b0, duty} + UPV;
        up_val   = (raised >= MAXW) ? MAXC : raised[CW-1:0];
        dn_val   = (duty >= FLOORV) ? (duty - DNV) : MINV;
        duty_nxt = (pk_over || pk_gross) ? dn_val : up_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty <= STARTV;
            skip <= 1'b0;
        end else if (load) begin
            duty <= STARTV;
            skip <= 1'b0;
        end else if (period_end) begin
            duty <= duty_nxt;
            skip <= pk_gross;
        end
    end
endmodule

// File: rtl/hbr_gate_seq.sv
`timescale 1ns/1ps
module hbr_gate_seq
    import hbr_pkg::*;
#(
    parameter int DUTY_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            drv_en,
    input  logic            prot_off,
    input  logic [DUTY_W:0] phase,
    input  logic [DUTY_W:0] duty,
    input  logic            skip,
    output gate_state_t     state,
    output logic            hs_on,
    output logic            ls_on
);
    localparam int PW = DUTY_W + 1;
    localparam logic [PW-1:0] LAST = '1;

    gate_state_t state_nxt;
    logic        hs_raw;
    logic        ls_raw;

    always_comb begin
        state_nxt = state;
        unique case (state)
            GS_IDLE: if (drv_en) state_nxt = GS_LEAD;
            GS_LEAD: state_nxt = drv_en ? GS_RUN : GS_IDLE;
            GS_RUN:  if (!drv_en) state_nxt = GS_TAIL;
            GS_TAIL: state_nxt = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        hs_raw = 1'b0;
        ls_raw = 1'b0;
        unique case (state)
            GS_IDLE: ls_raw = 1'b1;
            GS_LEAD: ls_raw = 1'b0;
            GS_TAIL: ls_raw = 1'b0;
            GS_RUN: begin
                if (skip) begin
                    ls_raw = (phase != LAST);
                end else begin
                    hs_raw = (phase < duty);
                    ls_raw = (phase > duty) && (phase != LAST);
                end
            end
        endcase
        hs_on = hs_raw && !prot_off;
        ls_on = ls_raw && !prot_off;
    end
endmodule

// File: rtl/hb_duty_regulator.sv
`timescale 1ns/1ps
module hb_duty_regulator
    import hbr_pkg::*;
#(
    parameter int DUTY_W     = 6,
    parameter int START_DUTY = 32,
    parameter int UP_STEP    = 11,
    parameter int DN_STEP    = 4,
    parameter int MIN_DUTY   = 9,
    parameter int MAX_DUTY   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic pk_over,
    input  logic pk_gross,
    input  logic prot_off,
    output logic hs_on,
    output logic ls_on
);
    gate_state_t     state;
    logic [DUTY_W:0] phase;
    logic [DUTY_W:0] duty_code;
    logic            period_end;
    logic            skip;

    hbr_phase_ctr #(.DUTY_W(DUTY_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state == GS_RUN),
        .phase      (phase),
        .period_end (period_end)
    );

    hbr_duty_servo #(
        .DUTY_W     (DUTY_W),
        .START_DUTY (START_DUTY),
        .UP_STEP    (UP_STEP),
        .DN_STEP    (DN_STEP),
        .MIN_DUTY   (MIN_DUTY),
        .MAX_DUTY   (MAX_DUTY)
    ) u_servo (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state == GS_LEAD),
        .period_end (period_end),
        .pk_over    (pk_over),
        .pk_gross   (pk_gross),
        .duty       (duty_code),
        .skip       (skip)
    );

    hbr_gate_seq #(.DUTY_W(DUTY_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_en   (drv_en),
        .prot_off (prot_off),
        .phase    (phase),
        .duty     (duty_code),
        .skip     (skip),
        .state    (state),
        .hs_on    (hs_on),
        .ls_on    (ls_on)
    );
endmodule

// File: rtl/hbr_checker.sv
`timescale 1ns/1ps
module hbr_checker #(
    parameter int DUTY_W   = 6,
    parameter int MIN_DUTY = 9,
    parameter int MAX_DUTY = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            drv_en,
    input logic            prot_off,
    input logic            hs_on,
    input logic            ls_on,
    input logic [DUTY_W:0] duty
);
    localparam int CW = DUTY_W + 1;
    localparam logic [CW-1:0] MINC = CW'(MIN_DUTY);
    localparam logic [CW-1:0] MAXC = CW'(MAX_DUTY);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    p_dead_after_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |=> !ls_on);

    p_dead_after_ls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ls_on |=> !hs_on);

    p_prot_forces_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_off |-> (!hs_on && !ls_on));

    p_idle_low_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!drv_en, 1) && $past(!drv_en, 2) && !prot_off) |-> (ls_on && !hs_on));

    p_duty_bounds_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty >= MINC) && (duty <= MAXC));
endmodule

bind hb_duty_regulator hbr_checker #(
    .DUTY_W   (DUTY_W),
    .MIN_DUTY (MIN_DUTY),
    .MAX_DUTY (MAX_DUTY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv_en   (drv_en),
    .prot_off (prot_off),
    .hs_on    (hs_on),
    .ls_on    (ls_on),
    .duty     (duty_code)
);

// File: tb/test_hb_duty_regulator.sv
`timescale 1ns/1ps
module test_hb_duty_regulator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_en = 1'b0;
    logic pk_over = 1'b0;
    logic pk_gross = 1'b0;
    logic prot_off = 1'b0;
    logic hs_on;
    logic ls_on;

    int n_tests = 0;
    int n_fail  = 0;
    bit prev_hs = 1'b0;
    bit prev_ls = 1'b0;

    always #2.5 clk = ~clk;

    hb_duty_regulator i_hb_duty_regulator (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .pk_over(pk_over),
        .pk_gross(pk_gross), .prot_off(prot_off), .hs_on(hs_on), .ls_on(ls_on)
    );

    // over, gross, hold-to-end, expected high-side slots in that period
    typedef struct packed {
        logic       over;
        logic       gross;
        logic       hold;
        logic [7:0] exp_hs;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 8'd32},  // R1 start at half
        '{1'b0, 1'b0, 1'b1, 8'd43},  // R2 ramp
        '{1'b0, 1'b0, 1'b1, 8'd54},  // R2 ramp
        '{1'b0, 1'b0, 1'b1, 8'd64},  // R3 clamp at full
        '{1'b1, 1'b0, 1'b1, 8'd64},  // R3 held at full
        '{1'b1, 1'b0, 1'b1, 8'd60},  // R4 step down
        '{1'b0, 1'b1, 1'b1, 8'd56},  // R4 step down
        '{1'b0, 1'b0, 1'b1, 8'd0},   // R5 skipped pulse, duty 52->63
        '{1'b1, 1'b0, 1'b1, 8'd63},  // R2 rise continued through skip
        '{1'b1, 1'b0, 1'b1, 8'd59},  // R4
        '{1'b1, 1'b0, 1'b0, 8'd55},  // R10 flag dropped before slot 127
        '{1'b0, 1'b0, 1'b1, 8'd64}   // R10 duty rose as if no flag
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one 128-slot period; flags set at slot 0 and, when hd=0, cleared at slot 64.
    task automatic run_period(input logic ov, input logic gr, input logic hd, input int e,
                              output int hs_n, output int ls_n, output int bad);
        hs_n = 0;
        ls_n = 0;
        bad  = 0;
        pk_over  = ov;
        pk_gross = gr;
        for (int i = 0; i < 128; i++) begin
            bit eh;
            bit el;
            if (!hd && i == 64) begin
                pk_over  = 1'b0;
                pk_gross = 1'b0;
            end
            eh = (i < e);
            el = (e == 0) ? (i != 127) : ((i > e) && (i != 127));
            if (hs_on) hs_n++;
            if (ls_on) ls_n++;
            if (hs_on !== eh || ls_on !== el) bad++;
            if (hs_on && ls_on) bad++;
            if ((prev_hs && ls_on) || (prev_ls && hs_on)) bad++;
            prev_hs = hs_on;
            prev_ls = ls_on;
            tick();
        end
    endtask

    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int hs_n;
        int ls_n;
        int bad;

        repeat (3) tick();
        chk(hs_on == 1'b0 && ls_on == 1'b1, "R7 reset state ls", {30'd0, hs_on, ls_on}, 1);
        rst_n = 1'b1;
        tick();
        chk(hs_on == 1'b0 && ls_on == 1'b1, "R7 idle after reset", {30'd0, hs_on, ls_on}, 1);

        // first burst
        drv_en = 1'b1;
        tick();
        chk(!hs_on && !ls_on, "R7 lead slot all off", {30'd0, hs_on, ls_on}, 0);
        tick();
        prev_hs = 1'b0;
        prev_ls = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            int e;
            e = int'(VEC[v].exp_hs);
            run_period(VEC[v].over, VEC[v].gross, VEC[v].hold, e, hs_n, ls_n, bad);
            chk(hs_n == e, "R1/R2/R3/R4/R5/R10 high-side slots", hs_n, e);
            chk(ls_n == ((e == 0) ? 127 : 126 - e), "R5/R6 low-side slots", ls_n,
                (e == 0) ? 127 : 126 - e);
            chk(bad == 0, "R6/R8 slot pattern and dead time", bad, 0);
        end
        pk_over  = 1'b0;
        pk_gross = 1'b0;

        // protection override, now at slot 0 with duty 64
        prot_off = 1'b1;
        #1;
        chk(!hs_on && !ls_on, "R9 prot during high side", {30'd0, hs_on, ls_on}, 0);
        repeat (80) tick();
        chk(!hs_on && !ls_on, "R9 prot during low side", {30'd0, hs_on, ls_on}, 0);
        prot_off = 1'b0;
        #1;
        chk(!hs_on && ls_on, "R9 release restores slot 80 low side", {30'd0, hs_on, ls_on}, 1);

        // end burst
        drv_en = 1'b0;
        tick();
        chk(!hs_on && !ls_on, "R7 tail slot all off", {30'd0, hs_on, ls_on}, 0);
        tick();
        chk(!hs_on && ls_on, "R7 idle low side after burst", {30'd0, hs_on, ls_on}, 1);

        // second burst: restart at half, walk to the floor
        drv_en = 1'b1;
        tick();
        tick();
        prev_hs = 1'b0;
        prev_ls = 1'b0;
        begin
            int exp_seq [8] = '{32, 28, 24, 20, 16, 12, 9, 9};
            for (int p = 0; p < 8; p++) begin
                run_period(1'b1, 1'b0, 1'b1, exp_seq[p], hs_n, ls_n, bad);
                if (p == 0)
                    chk(hs_n == exp_seq[p], "R1 restart at half duty", hs_n, exp_seq[p]);
                else
                    chk(hs_n == exp_seq[p], "R4 step down to floor", hs_n, exp_seq[p]);
                chk(bad == 0, "R6/R8 slot pattern", bad, 0);
            end
        end
        pk_over = 1'b0;

        // disable while high side is on: dead slot before low side
        tick();
        drv_en = 1'b0;
        chk(hs_on && !ls_on, "R6 high side at slot 1", {30'd0, hs_on, ls_on}, 2);
        tick();
        chk(!hs_on && !ls_on, "R8 dead slot on exit", {30'd0, hs_on, ls_on}, 0);
        tick();
        chk(!hs_on && ls_on, "R7 ground after exit", {30'd0, hs_on, ls_on}, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule